// File: doc/BRIEF.md
# Per-Processor Interrupt Level Combiner

This block serves one processor. It holds a pending word that gathers three local request sources: software interrupts, a sticky non-maskable level-15 request, and a level-sensitive local timer. It merges them with the hardware interrupt levels that a system router delivers to this processor. The merged result drives fifteen registered request lines, one for each processor interrupt level from 1 to 15.

Software reaches the pending word through a small port addressed by word. One word reads the pending word. One word sets software interrupt bits. One word clears software bits and the level-15 bit. The fourth word is reserved. When this processor is the router's current target, the low pending bits also show the raw hardware levels, so software can inspect them. Arbitration between processors and the system routing logic sit outside this block. The routed level vector, the raw mirror vector and the target flag all arrive as inputs.

Top module: `cpu_level_merge`

## Requirements
- R1: While rst_ni is low, and after it is released, the pending word reads 0 and every irq_o line is 0 until some stimulus arrives.
- R2: A write to word 2 ORs wdata & 0xFFFE0000 into the pending word, so only bits 31:17 change. With no write, bits 31:16 keep their value.
- R3: A write to word 1 clears the pending bits selected by wdata & 0xFFFE8000. The timer bit 14 and the mirror bits 13:1 are not affected.
- R4: Reading word 0 returns the full pending word. Reads at words 1, 2 and 3 return 0.
- R5: Pending bit n+16 (software interrupt) requests level n, so irq_o[n] is high for n = 1..15.
- R6: Pending bit 14 follows timer_i with one clock of delay. It drives irq_o[14] whatever the target state.
- R7: A high nmi_i sets pending bit 15, which stays set until a word-1 clear removes it. If a set and a clear arrive in the same cycle, the set wins. Bit 15 drives irq_o[15] whatever the target state.
- R8: Pending bits 13:1 equal mirror_lvl_i[13:1] when target_i is high, and are 0 when it is low.
- R9: route_lvl_i[n] drives irq_o[n] only while target_i is high.
- R10: irq_o is registered. Each line takes its new value at the clock edge that samples the input change or register write causing it, and a line toggles only when its merged value differs from its current state.
- R11: A write to word 3 changes neither the pending word nor irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Word address: 0 pending, 1 clear, 2 set, 3 reserved |
| reg_wr_i | input | 1 | Write strobe for the addressed word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word |
| timer_i | input | 1 | Local timer request, sensed as a level |
| nmi_i | input | 1 | Level-15 request; sets a sticky pending bit |
| target_i | input | 1 | High while this processor is the router's target |
| route_lvl_i | input | 15 | Enabled hardware levels from the router, bit n for level n |
| mirror_lvl_i | input | 13 | Raw hardware levels 1..13 to show in the pending word |
| irq_o | output | 15 | Interrupt request lines, bit n for level n |

## Verification
The bench writes clear masks that include bit 14 and bit 16 alongside software bits. A design that cleared the timer bit, or that stored a software level 0, would show a wrong pending word. It asserts nmi_i in the same cycle as a clear of bit 15, which catches a design where the clear wins, and it drops target_i while routed and mirror levels stay high, which catches a design that leaks hardware levels to a processor that is not the target. Random traffic on all four words, including the reserved one, exposes offsets swapped between set and clear, and shows outputs that are one cycle late or combinational.

// File: rtl/cpu_lvl_pkg.sv
package cpu_lvl_pkg;
  typedef enum logic [1:0] {
    ADDR_PEND = 2'd0,
    ADDR_CLR  = 2'd1,
    ADDR_SET  = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;

  localparam int unsigned DEF_NUM_LVL   = 15;
  localparam int unsigned DEF_TIMER_LVL = 14;
  localparam int unsigned DEF_NMI_LVL   = 15;
endpackage

// File: rtl/pend_reg.sv
module pend_reg
  import cpu_lvl_pkg::*;
#(
  parameter int unsigned NUM_LVL   = DEF_NUM_LVL,
  parameter int unsigned TIMER_LVL = DEF_TIMER_LVL,
  parameter int unsigned NMI_LVL   = DEF_NMI_LVL,
  localparam int unsigned SOFT_LSB = NUM_LVL + 1,
  localparam int unsigned WORD_W   = 2 * SOFT_LSB
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [1:0]           addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic                 timer_i,
  input  logic                 nmi_i,
  input  logic                 target_i,
  input  logic [TIMER_LVL-1:1] mirror_lvl_i,
  output logic [WORD_W-1:0]    pend_o,
  output logic [WORD_W-1:0]    pend_d_o
);

  logic [WORD_W-1:0] soft_mask, clr_mask;
  logic [WORD_W-1:0] pend_q, pend_d;
  logic              set_wr, clr_wr;

  always_comb begin
    soft_mask = '0;
    for (int i = 1; i <= int'(NUM_LVL); i++) soft_mask[SOFT_LSB+i] = 1'b1;
    clr_mask = soft_mask;
    clr_mask[NMI_LVL] = 1'b1;
  end

  assign set_wr = wr_i && (addr_i == ADDR_SET);
  assign clr_wr = wr_i && (addr_i == ADDR_CLR);

  always_comb begin
    pend_d = pend_q;
    if (set_wr) pend_d = pend_d | (wdata_i & soft_mask);
    if (clr_wr) pend_d = pend_d & ~(wdata_i & clr_mask);
    // set beats clear on level 15
    if (nmi_i) pend_d[NMI_LVL] = 1'b1;
    pend_d[TIMER_LVL] = timer_i;
    for (int i = 1; i < int'(TIMER_LVL); i++) pend_d[i] = target_i & mirror_lvl_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o   = pend_q;
  assign pend_d_o = pend_d;

  logic past_vld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_vld_q <= 1'b0;
    else         past_vld_q <= 1'b1;
  end

  // R6
  timer_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q |-> pend_q[TIMER_LVL] == $past(timer_i));

  // R7
  nmi_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && $past(nmi_i)) |-> pend_q[NMI_LVL]);

  // R2
  soft_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && !$past(wr_i)) |-> pend_q[WORD_W-1:SOFT_LSB] == $past(pend_q[WORD_W-1:SOFT_LSB]));

  // R3
  soft_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && $past(clr_wr && wdata_i[SOFT_LSB+1])) |-> !pend_q[SOFT_LSB+1]);

endmodule

// File: rtl/level_merge.sv
module level_merge
  import cpu_lvl_pkg::*;
#(
  parameter int unsigned NUM_LVL   = DEF_NUM_LVL,
  parameter int unsigned TIMER_LVL = DEF_TIMER_LVL,
  parameter int unsigned NMI_LVL   = DEF_NMI_LVL
) (
  input  logic [NUM_LVL:1] soft_i,
  input  logic             tmr_i,
  input  logic             nmi_i,
  input  logic             target_i,
  input  logic [NUM_LVL:1] route_i,
  output logic [NUM_LVL:1] lvl_o
);

  for (genvar n = 1; n <= int'(NUM_LVL); n++) begin : g_lvl
    logic fixed;
    if (n == int'(TIMER_LVL)) begin : g_tmr
      assign fixed = tmr_i;
    end else if (n == int'(NMI_LVL)) begin : g_nmi
      assign fixed = nmi_i;
    end else begin : g_none
      assign fixed = 1'b0;
    end
    assign lvl_o[n] = soft_i[n] | (target_i & route_i[n]) | fixed;
  end

endmodule

// File: rtl/line_reg.sv
module line_reg
  import cpu_lvl_pkg::*;
#(
  parameter int unsigned NUM_LVL = DEF_NUM_LVL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_LVL:1] lvl_i,
  output logic [NUM_LVL:1] line_o
);

  for (genvar n = 1; n <= int'(NUM_LVL); n++) begin : g_line
    logic q;
    // raise or lower only on a difference
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              q <= 1'b0;
      else if (lvl_i[n] != q)   q <= lvl_i[n];
    end
    assign line_o[n] = q;
  end

endmodule

// File: rtl/cpu_level_merge.sv
module cpu_level_merge
  import cpu_lvl_pkg::*;
#(
  parameter int unsigned NUM_LVL   = DEF_NUM_LVL,
  parameter int unsigned TIMER_LVL = DEF_TIMER_LVL,
  parameter int unsigned NMI_LVL   = DEF_NMI_LVL,
  localparam int unsigned SOFT_LSB = NUM_LVL + 1,
  localparam int unsigned WORD_W   = 2 * SOFT_LSB
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic [WORD_W-1:0]    reg_wdata_i,
  output logic [WORD_W-1:0]    reg_rdata_o,
  input  logic                 timer_i,
  input  logic                 nmi_i,
  input  logic                 target_i,
  input  logic [NUM_LVL:1]     route_lvl_i,
  input  logic [TIMER_LVL-1:1] mirror_lvl_i,
  output logic [NUM_LVL:1]     irq_o
);

  logic [WORD_W-1:0] pend_q, pend_d;
  logic [NUM_LVL:1]  lvl_d;

  pend_reg #(
    .NUM_LVL  (NUM_LVL),
    .TIMER_LVL(TIMER_LVL),
    .NMI_LVL  (NMI_LVL)
  ) pend_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .timer_i     (timer_i),
    .nmi_i       (nmi_i),
    .target_i    (target_i),
    .mirror_lvl_i(mirror_lvl_i),
    .pend_o      (pend_q),
    .pend_d_o    (pend_d)
  );

  // next-state pending feeds the merge so lines move with the word
  level_merge #(
    .NUM_LVL  (NUM_LVL),
    .TIMER_LVL(TIMER_LVL),
    .NMI_LVL  (NMI_LVL)
  ) merge_i (
    .soft_i  (pend_d[WORD_W-1:SOFT_LSB+1]),
    .tmr_i   (pend_d[TIMER_LVL]),
    .nmi_i   (pend_d[NMI_LVL]),
    .target_i(target_i),
    .route_i (route_lvl_i),
    .lvl_o   (lvl_d)
  );

  line_reg #(
    .NUM_LVL(NUM_LVL)
  ) line_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_d),
    .line_o(irq_o)
  );

  assign reg_rdata_o = (reg_addr_i == ADDR_PEND) ? pend_q : '0;

  logic past_vld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_vld_q <= 1'b0;
    else         past_vld_q <= 1'b1;
  end

  // R9
  no_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && $past(!target_i && pend_d == '0)) |-> irq_o == '0);

  // R7
  nmi_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[NMI_LVL] |-> irq_o[NMI_LVL]);

  // R6
  timer_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[TIMER_LVL] |-> irq_o[TIMER_LVL]);

  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pend_q == '0 && irq_o == '0));

endmodule

// File: tb/cpu_level_merge_tb_top.sv
module cpu_level_merge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tmr = 1'b0;
  logic        nmi = 1'b0;
  logic        tgt = 1'b0;
  logic [15:1] route = '0;
  logic [13:1] mirror = '0;
  logic [15:1] irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_pend = '0;
  logic [15:1] m_irq = '0;

  always #10 clk = ~clk;

  cpu_level_merge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .timer_i(tmr), .nmi_i(nmi),
    .target_i(tgt), .route_lvl_i(route), .mirror_lvl_i(mirror), .irq_o(irq)
  );

  function automatic logic [31:0] f_next(logic [31:0] p, logic [1:0] a, logic w,
      logic [31:0] d, logic tm, logic nm, logic tg, logic [13:1] mr);
    logic [31:0] x = p;
    if (w && a == 2'd2) x = x | (d & 32'hFFFE0000);
    if (w && a == 2'd1) x = x & ~(d & 32'hFFFE8000);
    if (nm) x[15] = 1'b1;
    x[14] = tm;
    for (int i = 1; i <= 13; i++) x[i] = tg & mr[i];
    return x;
  endfunction

  function automatic logic [15:1] f_irq(logic [31:0] p, logic tg, logic [15:1] rt);
    logic [15:1] v;
    for (int l = 1; l <= 15; l++) v[l] = p[16+l] | (tg & rt[l]);
    v[14] = v[14] | p[14];
    v[15] = v[15] | p[15];
    return v;
  endfunction

  task automatic chk32(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic step(string tag, logic [1:0] a, logic w, logic [31:0] d, logic tm,
      logic nm, logic tg, logic [15:1] rt, logic [13:1] mr);
    @(negedge clk);
    addr = a; wr = w; wdata = d; tmr = tm; nmi = nm; tgt = tg; route = rt; mirror = mr;
    @(posedge clk);
    #2;
    m_pend = f_next(m_pend, a, w, d, tm, nm, tg, mr);
    m_irq  = f_irq(m_pend, tg, rt);
    chk32(tag, "irq_o", {17'd0, irq}, {17'd0, m_irq});
    chk32(tag, "rdata", rdata, (a == 2'd0) ? m_pend : 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got running exp done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk32("R1", "rdata", rdata, 32'd0);
    chk32("R1", "irq_o", {17'd0, irq}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    step("R1", 2'd0, 1'b0, '0, 0, 0, 0, '0, '0);
    // R2 R5 set all soft bits; bit 16 must stay clear
    step("R2", 2'd2, 1'b1, 32'hFFFFFFFF, 0, 0, 0, '0, '0);
    step("R5", 2'd0, 1'b0, '0, 0, 0, 0, '0, '0);
    // R3 clear everything through word 1
    step("R3", 2'd1, 1'b1, 32'hFFFFFFFF, 0, 0, 0, '0, '0);
    // R5 single soft level 3
    step("R5", 2'd2, 1'b1, 32'h00080000, 0, 0, 0, '0, '0);
    step("R4", 2'd0, 1'b0, '0, 0, 0, 0, '0, '0);
    // R6 timer plus clear attempt of bit 14
    step("R6", 2'd0, 1'b0, '0, 1, 0, 0, '0, '0);
    step("R3", 2'd1, 1'b1, 32'h00004000, 1, 0, 0, '0, '0);
    step("R6", 2'd0, 1'b0, '0, 0, 0, 0, '0, '0);
    // R7 sticky, set wins over clear, then clear
    step("R7", 2'd0, 1'b0, '0, 0, 1, 0, '0, '0);
    step("R7", 2'd0, 1'b0, '0, 0, 0, 0, '0, '0);
    step("R7", 2'd1, 1'b1, 32'h00008000, 0, 1, 0, '0, '0);
    step("R7", 2'd1, 1'b1, 32'h00008000, 0, 0, 0, '0, '0);
    // R8 R9 target mirror and routing
    step("R8", 2'd0, 1'b0, '0, 0, 0, 1, 15'h2AAA, 13'h1555);
    step("R9", 2'd0, 1'b0, '0, 0, 0, 0, 15'h7FFF, 13'h1FFF);
    // R11 reserved word write
    step("R11", 2'd3, 1'b1, 32'hFFFFFFFF, 0, 0, 0, '0, '0);
    step("R11", 2'd0, 1'b0, '0, 0, 0, 0, '0, '0);
    // R10 random mix
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      step("R10", a, 1'($urandom), $urandom, 1'($urandom),
           ($urandom_range(0, 7) == 0), 1'($urandom), 15'($urandom), 13'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule